// File: doc/BRIEF.md
# Next-PC Fixed-Priority Redirect Arbiter

This block owns the fetch address of an in-order RISC-V style pipeline that supports 16-bit compressed instructions. It keeps the PC register and issues one fetch request at a time to the instruction-side buffers. The request stays up until the buffers answer it. It accepts the answer into a one-entry slot, and hands the fetched instruction to decode over a valid/ready handshake. Without a redirect, the PC advances by the size of the instruction just fetched.

Four sources can redirect the PC, each over a valid/ready handshake. In falling priority they are: the trap unit (exceptions, interrupts, trap return), the execute stage (taken branches), the memory-access stage (fence.i completion and CSR side effects), and fetch's own jump logic (immediate and register jumps). A memory-stage redirect that is flagged as a fence is held back. It waits until no fetch is outstanding and the instruction cache reports that its flush is done. While such a fence waits, no new fetch is started. When a redirect wins, any fetch still in flight is marked stale and its answer is dropped. Redirects from the three older stages also empty the decode slot.

Top module: `npc_redirect_arb`

## Requirements
- R1: While reset is low, fetch_req_valid and dec_valid are 0. In the first cycle after reset is released, fetch_req_valid is still 0. In the cycle after that, it is 1 with fetch_req_pc equal to the RESET_PC parameter.
- R2: In any cycle at most one ready output is high, and it belongs to the highest-priority source that is eligible. Priority order is trap, then execute, then memory stage, then jump. A memory-stage request that is present but not yet eligible also blocks the jump source. The winning pc becomes the address of the next fetch.
- R3: After a fetch answer is accepted with no redirect in the same cycle, the next fetch address is the accepted pc plus 2 when fetch_rsp_rvc is 1, and plus 4 when it is 0.
- R4: Once fetch_req_valid is 1, it and fetch_req_pc stay unchanged until a cycle in which fetch_rsp_valid is 1. At most one fetch is outstanding.
- R5: A memory-stage request with mem_fence=1 gets mem_ready only when no fetch is outstanding and ic_flush_done is 1. While such a request waits, no new fetch is issued.
- R6: A fetch answer that arrives in the cycle a redirect wins is not forwarded to decode. The same holds for an answer to a request that was outstanding when an earlier redirect won.
- R7: An answer with fetch_rsp_excp=1 is forwarded with dec_excp=1, dec_cause equal to fetch_rsp_cause, and dec_inst forced to 0. Without an exception, dec_inst carries the instruction and dec_excp is 0.
- R8: dec_valid, dec_pc and dec_inst hold steady until dec_ready is 1. A new fetch is issued only when the decode slot is empty, or is emptied in that cycle.
- R9: A winning trap, execute or memory-stage redirect empties the decode slot. A winning jump redirect leaves it intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap unit redirect request |
| trap_pc | input | PC_W | Trap unit target |
| trap_ready | output | 1 | Trap redirect accepted |
| exec_valid | input | 1 | Execute stage redirect request |
| exec_pc | input | PC_W | Branch target |
| exec_ready | output | 1 | Execute redirect accepted |
| mem_valid | input | 1 | Memory-stage redirect request |
| mem_pc | input | PC_W | Memory-stage target |
| mem_fence | input | 1 | Request completes a fence.i and must wait for drain and flush |
| mem_ready | output | 1 | Memory-stage redirect accepted |
| ic_flush_done | input | 1 | Instruction cache flush has completed |
| jmp_valid | input | 1 | Fetch-side jump redirect request |
| jmp_pc | input | PC_W | Jump target |
| jmp_ready | output | 1 | Jump redirect accepted |
| fetch_req_valid | output | 1 | Fetch request enable, held until answered |
| fetch_req_pc | output | PC_W | Fetch address |
| fetch_rsp_valid | input | 1 | Fetch answer present |
| fetch_rsp_inst | input | INST_W | Fetched instruction |
| fetch_rsp_rvc | input | 1 | Fetched instruction is compressed |
| fetch_rsp_excp | input | 1 | Fetch raised an exception |
| fetch_rsp_cause | input | CAUSE_W | Exception cause |
| dec_valid | output | 1 | Instruction offered to decode |
| dec_ready | input | 1 | Decode takes the instruction |
| dec_pc | output | PC_W | PC of the offered instruction |
| dec_inst | output | INST_W | Instruction, zero when excepting |
| dec_excp | output | 1 | Offered instruction carries an exception |
| dec_cause | output | CAUSE_W | Exception cause |

## Verification
The bench holds losing redirect requests, as the handshake demands. It then lands redirects in the same cycle as fetch answers, while answers are still pending, and against a waiting fence. An arbiter with a wrong stale-answer rule would send decode an instruction from the abandoned path. One that skips the drain condition would accept a fence with a fetch still in flight. The bench also mixes compressed and full-size answers, exception answers and a stalling decode port. A wrong increment, a leaked instruction word, or a slot that refills early would show up as a mismatch in the next-fetch pc or in the decode fields. Jump redirects arrive while the slot is full, to separate the slot-flushing sources from the one that must leave the slot intact.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int NUM_SRC  = 4;
  localparam int SRC_TRAP = 0;
  localparam int SRC_EXEC = 1;
  localparam int SRC_MEM  = 2;
  localparam int SRC_JMP  = 3;
endpackage

// File: rtl/npc_prio_sel.sv
module npc_prio_sel #(
  parameter int N    = 4,
  parameter int PC_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    src_vld,
  input  logic [N-1:0]    src_elig,
  input  logic [PC_W-1:0] src_pc [N],
  output logic [N-1:0]    src_rdy,
  output logic            sel_any,
  output logic [PC_W-1:0] sel_pc
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign src_rdy[i]     = src_vld[i] & src_elig[i] & ~blocked[i];
    assign blocked[i + 1] = blocked[i] | src_vld[i];
  end

  always_comb begin
    sel_pc = '0;
    for (int i = 0; i < N; i++) begin
      if (src_rdy[i]) sel_pc = src_pc[i];
    end
  end
  assign sel_any = |src_rdy;

  a_r2_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_rdy));
  a_r2_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    src_vld[0] |-> src_rdy[0]);
endmodule

// File: rtl/npc_fetch_ctl.sv
module npc_fetch_ctl #(
  parameter int              PC_W     = 64,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redir,
  input  logic [PC_W-1:0] redir_pc,
  input  logic            rsp_valid,
  input  logic            rsp_rvc,
  input  logic            slot_busy_d,
  input  logic            fence_hold,
  output logic            req_valid,
  output logic [PC_W-1:0] req_pc,
  output logic            accept
);
  logic            req_q, req_d;
  logic            drop_q, drop_d;
  logic [PC_W-1:0] pc_q, pc_d, rpc_q;
  logic            take, discard, issue, pc_en, drop_en, rpc_en;

  always_comb begin
    take    = req_q & rsp_valid;
    discard = take & (drop_q | redir);
    accept  = take & ~discard;
    pc_en   = redir | accept;
    pc_d    = redir ? redir_pc : (pc_q + (rsp_rvc ? PC_W'(2) : PC_W'(4)));
    drop_en = take | (redir & req_q);
    drop_d  = ~take;
    issue   = ~req_q & ~slot_busy_d & ~fence_hold;
    req_d   = req_q ? ~rsp_valid : issue;
    rpc_en  = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      rpc_q  <= RESET_PC;
      req_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (pc_en)   pc_q   <= pc_d;
      if (drop_en) drop_q <= drop_d;
      if (rpc_en)  rpc_q  <= pc_en ? pc_d : pc_q;
    end
  end

  assign req_valid = req_q;
  assign req_pc    = rpc_q;

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & ~rsp_valid) |=> (req_valid & $stable(req_pc)));
  a_r6_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & rsp_valid & redir) |-> ~accept);
endmodule

// File: rtl/npc_out_slot.sv
module npc_out_slot #(
  parameter int PC_W    = 64,
  parameter int INST_W  = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PC_W-1:0]    ld_pc,
  input  logic [INST_W-1:0]  ld_inst,
  input  logic               ld_excp,
  input  logic [CAUSE_W-1:0] ld_cause,
  input  logic               flush,
  input  logic               ready,
  output logic               busy_d,
  output logic               valid,
  output logic [PC_W-1:0]    pc,
  output logic [INST_W-1:0]  inst,
  output logic               excp,
  output logic [CAUSE_W-1:0] cause
);
  logic v_q, v_d;

  always_comb v_d = load | (v_q & ~(flush | ready));
  assign busy_d = v_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      pc    <= '0;
      inst  <= '0;
      excp  <= 1'b0;
      cause <= '0;
    end else begin
      v_q <= v_d;
      if (load) begin
        pc    <= ld_pc;
        inst  <= ld_excp ? '0 : ld_inst;
        excp  <= ld_excp;
        cause <= ld_excp ? ld_cause : '0;
      end
    end
  end
  assign valid = v_q;

  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid & ~ready & ~flush) |=> (valid & $stable(pc) & $stable(inst)));
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (flush & ~load) |=> ~valid);
  a_r7_excp_no_inst: assert property (@(posedge clk) disable iff (!rst_n)
    (valid & excp) |-> (inst == '0));
endmodule

// File: rtl/npc_redirect_arb.sv
module npc_redirect_arb
  import npc_pkg::*;
#(
  parameter int               PC_W     = 64,
  parameter int               INST_W   = 32,
  parameter int               CAUSE_W  = 5,
  parameter logic [PC_W-1:0]  RESET_PC = 64'h0000_0000_8000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_valid,
  input  logic [PC_W-1:0]    trap_pc,
  output logic               trap_ready,
  input  logic               exec_valid,
  input  logic [PC_W-1:0]    exec_pc,
  output logic               exec_ready,
  input  logic               mem_valid,
  input  logic [PC_W-1:0]    mem_pc,
  input  logic               mem_fence,
  output logic               mem_ready,
  input  logic               ic_flush_done,
  input  logic               jmp_valid,
  input  logic [PC_W-1:0]    jmp_pc,
  output logic               jmp_ready,
  output logic               fetch_req_valid,
  output logic [PC_W-1:0]    fetch_req_pc,
  input  logic               fetch_rsp_valid,
  input  logic [INST_W-1:0]  fetch_rsp_inst,
  input  logic               fetch_rsp_rvc,
  input  logic               fetch_rsp_excp,
  input  logic [CAUSE_W-1:0] fetch_rsp_cause,
  output logic               dec_valid,
  input  logic               dec_ready,
  output logic [PC_W-1:0]    dec_pc,
  output logic [INST_W-1:0]  dec_inst,
  output logic               dec_excp,
  output logic [CAUSE_W-1:0] dec_cause
);
  logic [NUM_SRC-1:0] vld, elig, rdy;
  logic [PC_W-1:0]    pcs [NUM_SRC];
  logic               redir, accept, flush, fence_hold, slot_busy_d;
  logic [PC_W-1:0]    redir_pc;

  always_comb begin
    vld            = '0;
    vld[SRC_TRAP]  = trap_valid;
    vld[SRC_EXEC]  = exec_valid;
    vld[SRC_MEM]   = mem_valid;
    vld[SRC_JMP]   = jmp_valid;
    elig           = '1;
    elig[SRC_MEM]  = ~mem_fence | (ic_flush_done & ~fetch_req_valid);
    pcs[SRC_TRAP]  = trap_pc;
    pcs[SRC_EXEC]  = exec_pc;
    pcs[SRC_MEM]   = mem_pc;
    pcs[SRC_JMP]   = jmp_pc;
  end

  npc_prio_sel #(.N(NUM_SRC), .PC_W(PC_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .src_vld(vld), .src_elig(elig), .src_pc(pcs),
    .src_rdy(rdy), .sel_any(redir), .sel_pc(redir_pc)
  );

  assign trap_ready = rdy[SRC_TRAP];
  assign exec_ready = rdy[SRC_EXEC];
  assign mem_ready  = rdy[SRC_MEM];
  assign jmp_ready  = rdy[SRC_JMP];
  assign flush      = rdy[SRC_TRAP] | rdy[SRC_EXEC] | rdy[SRC_MEM];
  assign fence_hold = mem_valid & mem_fence & ~rdy[SRC_MEM];

  npc_fetch_ctl #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .redir(redir), .redir_pc(redir_pc),
    .rsp_valid(fetch_rsp_valid), .rsp_rvc(fetch_rsp_rvc),
    .slot_busy_d(slot_busy_d), .fence_hold(fence_hold),
    .req_valid(fetch_req_valid), .req_pc(fetch_req_pc), .accept(accept)
  );

  npc_out_slot #(.PC_W(PC_W), .INST_W(INST_W), .CAUSE_W(CAUSE_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(accept), .ld_pc(fetch_req_pc),
    .ld_inst(fetch_rsp_inst), .ld_excp(fetch_rsp_excp), .ld_cause(fetch_rsp_cause),
    .flush(flush), .ready(dec_ready), .busy_d(slot_busy_d),
    .valid(dec_valid), .pc(dec_pc), .inst(dec_inst), .excp(dec_excp), .cause(dec_cause)
  );

  a_r5_fence_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ready & mem_fence) |-> (~fetch_req_valid & ic_flush_done));
  a_r5_no_issue_on_fence: assert property (@(posedge clk) disable iff (!rst_n)
    (~fetch_req_valid & fence_hold) |=> ~fetch_req_valid);
endmodule

// File: tb/npc_redirect_arb_tb.sv
module npc_redirect_arb_tb;
  localparam int PC_W = 64, INST_W = 32, CAUSE_W = 5;
  localparam logic [PC_W-1:0] RESET_PC = 64'h0000_0000_8000_0000;
  localparam int NCYC = 6000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic trap_valid = 0, exec_valid = 0, mem_valid = 0, jmp_valid = 0;
  logic [PC_W-1:0] trap_pc = 0, exec_pc = 0, mem_pc = 0, jmp_pc = 0;
  logic mem_fence = 0, ic_flush_done = 0;
  logic trap_ready, exec_ready, mem_ready, jmp_ready;
  logic fetch_req_valid; logic [PC_W-1:0] fetch_req_pc;
  logic fetch_rsp_valid = 0, fetch_rsp_rvc = 0, fetch_rsp_excp = 0;
  logic [INST_W-1:0] fetch_rsp_inst = 0; logic [CAUSE_W-1:0] fetch_rsp_cause = 0;
  logic dec_valid, dec_ready = 0, dec_excp;
  logic [PC_W-1:0] dec_pc; logic [INST_W-1:0] dec_inst; logic [CAUSE_W-1:0] dec_cause;

  npc_redirect_arb #(.PC_W(PC_W), .INST_W(INST_W), .CAUSE_W(CAUSE_W), .RESET_PC(RESET_PC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .trap_valid(trap_valid), .trap_pc(trap_pc), .trap_ready(trap_ready),
    .exec_valid(exec_valid), .exec_pc(exec_pc), .exec_ready(exec_ready),
    .mem_valid(mem_valid), .mem_pc(mem_pc), .mem_fence(mem_fence), .mem_ready(mem_ready),
    .ic_flush_done(ic_flush_done),
    .jmp_valid(jmp_valid), .jmp_pc(jmp_pc), .jmp_ready(jmp_ready),
    .fetch_req_valid(fetch_req_valid), .fetch_req_pc(fetch_req_pc),
    .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_inst(fetch_rsp_inst),
    .fetch_rsp_rvc(fetch_rsp_rvc), .fetch_rsp_excp(fetch_rsp_excp),
    .fetch_rsp_cause(fetch_rsp_cause),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_pc(dec_pc),
    .dec_inst(dec_inst), .dec_excp(dec_excp), .dec_cause(dec_cause)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // reference state
  logic [PC_W-1:0] m_pc = RESET_PC, m_rpc = RESET_PC, m_opc = 0;
  bit m_req = 0, m_drop = 0, m_outv = 0, m_oexc = 0;
  logic [INST_W-1:0] m_oinst = 0; logic [CAUSE_W-1:0] m_ocause = 0;
  string last_tag = "R8";
  int won = -1;

  function automatic logic [PC_W-1:0] rnd_pc();
    return {32'h0, $urandom} & ~64'h1;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fetch_req_valid === 1'b0, "R1 req in reset", {63'h0, fetch_req_valid}, 0);
    chk(dec_valid === 1'b0, "R1 dec in reset", {63'h0, dec_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int dens, w;
      bit take, redir, discard, accept, flush, issue, outv_n;
      logic [PC_W-1:0] rpc, pc_n;
      // consume last cycle's win
      if (won == 0) trap_valid = 0;
      if (won == 1) exec_valid = 0;
      if (won == 2) mem_valid = 0;
      if (won == 3) jmp_valid = 0;
      dens = (cyc < 2) ? 0 : ((cyc / 1000) % 3 == 0) ? 40 : ((cyc / 1000) % 3 == 1) ? 12 : 6;
      if (dens != 0) begin
        if (!trap_valid && ($urandom % (dens * 2)) == 0) begin trap_valid = 1; trap_pc = rnd_pc(); end
        if (!exec_valid && ($urandom % dens) == 0) begin exec_valid = 1; exec_pc = rnd_pc(); end
        if (!mem_valid && ($urandom % dens) == 0) begin
          mem_valid = 1; mem_pc = rnd_pc(); mem_fence = ($urandom % 2) == 0;
        end
        if (!jmp_valid && ($urandom % dens) == 0) begin jmp_valid = 1; jmp_pc = rnd_pc(); end
      end
      ic_flush_done   = ($urandom % 3) != 0;
      dec_ready       = ($urandom % 4) != 0;
      fetch_rsp_valid = m_req && (($urandom % 3) == 0);
      fetch_rsp_inst  = $urandom;
      fetch_rsp_rvc   = $urandom % 2;
      fetch_rsp_excp  = ($urandom % 8) == 0;
      fetch_rsp_cause = CAUSE_W'($urandom);
      #1;
      // expected arbitration
      if (trap_valid) begin w = 0; rpc = trap_pc; end
      else if (exec_valid) begin w = 1; rpc = exec_pc; end
      else if (mem_valid && (!mem_fence || (ic_flush_done && !m_req))) begin w = 2; rpc = mem_pc; end
      else if (!mem_valid && jmp_valid) begin w = 3; rpc = jmp_pc; end
      else begin w = -1; rpc = 0; end
      // compare
      if (cyc == 0) chk(fetch_req_valid === 1'b0, "R1 first cycle", {63'h0, fetch_req_valid}, 0);
      if (cyc == 1) chk(fetch_req_valid === 1'b1 && fetch_req_pc === RESET_PC, "R1 first fetch", fetch_req_pc, RESET_PC);
      chk(trap_ready === (w == 0), "R2 trap_ready", {63'h0, trap_ready}, {63'h0, w == 0});
      chk(exec_ready === (w == 1), "R2 exec_ready", {63'h0, exec_ready}, {63'h0, w == 1});
      chk(mem_ready === (w == 2), mem_fence ? "R5 mem_ready fence" : "R2 mem_ready", {63'h0, mem_ready}, {63'h0, w == 2});
      chk(jmp_ready === (w == 3), "R2 jmp_ready", {63'h0, jmp_ready}, {63'h0, w == 3});
      chk(fetch_req_valid === m_req, (mem_valid && mem_fence) ? "R5 req_valid" : "R4 req_valid",
          {63'h0, fetch_req_valid}, {63'h0, m_req});
      if (m_req) chk(fetch_req_pc === m_rpc, "R3 req_pc", fetch_req_pc, m_rpc);
      chk(dec_valid === m_outv, last_tag, {63'h0, dec_valid}, {63'h0, m_outv});
      if (m_outv) begin
        chk(dec_pc === m_opc, "R8 dec_pc", dec_pc, m_opc);
        chk(dec_inst === m_oinst, "R7 dec_inst", {32'h0, dec_inst}, {32'h0, m_oinst});
        chk(dec_excp === m_oexc && dec_cause === m_ocause, "R7 dec_excp/cause",
            {58'h0, dec_excp, dec_cause}, {58'h0, m_oexc, m_ocause});
      end
      // next reference state
      redir   = (w >= 0);
      flush   = (w >= 0) && (w <= 2);
      take    = m_req && fetch_rsp_valid;
      discard = take && (m_drop || redir);
      accept  = take && !discard;
      pc_n    = redir ? rpc : accept ? m_rpc + (fetch_rsp_rvc ? 64'd2 : 64'd4) : m_pc;
      if (accept) begin
        outv_n = 1; m_opc = m_rpc; m_oexc = fetch_rsp_excp;
        m_oinst = fetch_rsp_excp ? '0 : fetch_rsp_inst;
        m_ocause = fetch_rsp_excp ? fetch_rsp_cause : '0;
      end else if (flush) outv_n = 0;
      else if (m_outv && dec_ready) outv_n = 0;
      else outv_n = m_outv;
      last_tag = flush ? "R9 dec_valid" : discard ? "R6 dec_valid" : "R8 dec_valid";
      if (take) m_drop = 0; else if (redir && m_req) m_drop = 1;
      issue = !m_req && !outv_n && !(mem_valid && mem_fence && w != 2);
      if (m_req) m_req = !fetch_rsp_valid;
      else m_req = issue;
      if (issue) m_rpc = pc_n;
      m_pc = pc_n; m_outv = outv_n;
      won = w;
      @(negedge clk);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule